// File: doc/BRIEF.md
# Triangle-Wave Frequency Dither Generator

This block produces a digital frequency-offset code that follows a linear triangle, for use as the spread-spectrum control word of a master oscillator. It runs on the master clock itself. Each sweep starts at zero offset, ramps steadily down to a selectable peak negative offset, and ramps back up to zero. One full sweep takes 4096 master cycles, so the sweep repeats at the master frequency divided by 4096. The offset is only ever zero or negative, which means the oscillator is pulled below its programmed frequency and never above it.

An enable input starts sweeping. While the enable is low and the generator is at zero, the code stays at zero. If the enable drops in the middle of a sweep, the sweep that is under way runs to its end, so the frequency returns smoothly to nominal with no jump. A depth-select input chooses the peak. With the default parameters, the shallow setting (about 2%) gives a peak of 32 codes and the deep setting (about 4%) gives a peak of 64 codes. The generator reads this select only when a sweep begins from zero offset, so every triangle keeps a single depth from start to end. A second output shows whether the sweep is currently moving toward the peak.

Top module: `tri_dither_gen`

## Requirements
- R1: While rst_i is high at a clock edge, the outputs after that edge are freq_ofs_o = 0 and sweep_fall_o = 0.
- R2: While spread_en_i is low and the offset is at zero, freq_ofs_o stays 0 and sweep_fall_o stays 0.
- R3: With spread_en_i held high, the sweep repeats every 4096 clock cycles. sweep_fall_o rises once per period, and successive rises are exactly 4096 cycles apart.
- R4: freq_ofs_o, read as a two's-complement number, is never greater than 0.
- R5: At the bottom of each triangle, freq_ofs_o equals minus the selected peak. With default parameters this is -64 (8'hC0) when depth_sel_i was 0 at sweep start, and -32 (8'hE0) when it was 1.
- R6: freq_ofs_o changes by at most one code between consecutive cycles.
- R7: sweep_fall_o is 1 on every cycle where the sweep position is stepping toward the peak and 0 otherwise. The first cycle after the enable is seen at zero has sweep_fall_o = 1.
- R8: If spread_en_i falls in the middle of a sweep, the sweep continues unchanged to zero offset and then holds at zero.
- R9: depth_sel_i is sampled only on the cycle a sweep starts from zero offset. A change during a sweep has no effect until the next sweep.
- R10: The cycle after the sweep starts, the position is 1. The position then rises by one per cycle to 2048 and falls by one per cycle back to 0. On every cycle freq_ofs_o = -floor(position × peak / 2048), in 8-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| spread_en_i | input | 1 | Sweep enable: 1 runs the triangle, 0 parks it at zero after the current sweep |
| depth_sel_i | input | 1 | Peak select: 1 shallow (32 codes), 0 deep (64 codes) |
| freq_ofs_o | output | 8 | Two's-complement frequency offset code, zero or negative |
| sweep_fall_o | output | 1 | High while the offset is moving toward its peak |

## Verification
The hardest cases to reach are a depth change and an enable drop that land in the middle of a sweep. Both only show up thousands of cycles into a triangle, and they matter only relative to where the sweep currently stands. The stimulus therefore runs several whole periods with the enable held high. It flips the depth select at a cycle count that falls inside a down-ramp, and later drops the enable inside another down-ramp. A cycle-by-cycle expected stream then shows whether the old depth and the running sweep were kept until zero.

// File: rtl/dither_pkg.sv
package dither_pkg;

    // Phase of the triangle sweep.
    typedef enum logic [1:0] {
        PH_ZERO = 2'd0,   // parked or passing through zero offset
        PH_FALL = 2'd1,   // moving toward the peak negative offset
        PH_RISE = 2'd2    // returning toward zero offset
    } sweep_phase_e;

    // Event bundle passed from the sequencer to the rest of the datapath.
    typedef struct packed {
        sweep_phase_e phase;
        logic         start;     // leaving zero offset this cycle
    } seq_evt_t;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Deep peak is defined as twice the shallow peak.
    function automatic int deep_of(input int shallow);
        return 2 * shallow;
    endfunction

endpackage

// File: rtl/dith_phase_seq.sv
module dith_phase_seq
    import dither_pkg::*;
#(
    parameter int HALF_LEN = 2048,
    localparam int POS_W = $clog2(HALF_LEN) + 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_en_i,
    output logic [POS_W-1:0] pos_o,
    output seq_evt_t         evt_o
);

    localparam logic [POS_W-1:0] LAST_FALL = POS_W'(HALF_LEN - 1);
    localparam logic [POS_W-1:0] ONE       = POS_W'(1);

    sweep_phase_e     phase_q, phase_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic             start_c;

    always_comb begin
        phase_d = phase_q;
        pos_d   = pos_q;
        start_c = 1'b0;
        unique case (phase_q)
            PH_ZERO: begin
                if (run_en_i) begin
                    phase_d = PH_FALL;
                    pos_d   = ONE;
                    start_c = 1'b1;
                end
            end
            PH_FALL: begin
                pos_d = pos_q + ONE;
                if (pos_q == LAST_FALL) begin
                    phase_d = PH_RISE;
                end
            end
            PH_RISE: begin
                pos_d = pos_q - ONE;
                if (pos_q == ONE) begin
                    phase_d = PH_ZERO;
                end
            end
            default: begin
                phase_d = PH_ZERO;
                pos_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_ZERO;
            pos_q   <= '0;
        end else begin
            phase_q <= phase_d;
            pos_q   <= pos_d;
        end
    end

    assign pos_o       = pos_q;
    assign evt_o.phase = phase_q;
    assign evt_o.start = start_c;

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_ZERO && !run_en_i) |=> (phase_q == PH_ZERO && pos_q == '0));

    // R8
    sweep_finish_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_RISE && pos_q != ONE) |=> (phase_q == PH_RISE));

    // R10
    fall_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_FALL) |=> (pos_q == $past(pos_q) + ONE));

    // R10
    rise_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_RISE) |=> (pos_q == $past(pos_q) - ONE));

    // R5
    pos_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pos_q <= POS_W'(HALF_LEN));

endmodule

// File: rtl/dith_depth_latch.sv
module dith_depth_latch #(
    parameter int PEAK_SHALLOW = 32,
    parameter int PEAK_DEEP    = 64,
    parameter int PEAK_W       = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              shallow_i,
    output logic [PEAK_W-1:0] peak_o
);

    localparam logic [PEAK_W-1:0] CODE_SHALLOW = PEAK_W'(PEAK_SHALLOW);
    localparam logic [PEAK_W-1:0] CODE_DEEP    = PEAK_W'(PEAK_DEEP);

    logic [PEAK_W-1:0] peak_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            peak_q <= CODE_DEEP;
        end else if (load_i) begin
            peak_q <= shallow_i ? CODE_SHALLOW : CODE_DEEP;
        end
    end

    assign peak_o = peak_q;

    // R9
    depth_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(peak_q));

    // R5
    depth_legal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (peak_q == CODE_SHALLOW) || (peak_q == CODE_DEEP));

endmodule

// File: rtl/dith_code_map.sv
module dith_code_map #(
    parameter int POS_W  = 12,
    parameter int PEAK_W = 7,
    parameter int SHIFT  = 11,
    localparam int OUT_W  = PEAK_W + 1,
    localparam int PROD_W = POS_W + PEAK_W
) (
    input  logic [POS_W-1:0]  pos_i,
    input  logic [PEAK_W-1:0] peak_i,
    output logic [PEAK_W-1:0] mag_o,
    output logic [OUT_W-1:0]  ofs_o
);

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod  = PROD_W'(pos_i) * PROD_W'(peak_i);
        mag_o = PEAK_W'(prod >> SHIFT);
        ofs_o = OUT_W'(0) - {1'b0, mag_o};
    end

endmodule

// File: rtl/tri_dither_gen.sv
module tri_dither_gen
    import dither_pkg::*;
#(
    parameter int HALF_LEN     = 2048,
    parameter int PEAK_SHALLOW = 32,
    localparam int PEAK_DEEP = deep_of(PEAK_SHALLOW),
    localparam int PEAK_W    = $clog2(PEAK_DEEP + 1),
    localparam int OUT_W     = PEAK_W + 1,
    localparam int POS_W     = $clog2(HALF_LEN) + 1,
    localparam int SHIFT     = $clog2(HALF_LEN)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             spread_en_i,
    input  logic             depth_sel_i,
    output logic [OUT_W-1:0] freq_ofs_o,
    output logic             sweep_fall_o
);

    generate
        if (!is_pow2(HALF_LEN)) begin : g_bad_len
            $error("HALF_LEN must be a power of two");
        end
        if (PEAK_DEEP > HALF_LEN) begin : g_bad_peak
            $error("peak depth exceeds ramp length");
        end
    endgenerate

    logic [POS_W-1:0]  pos;
    seq_evt_t          evt;
    logic [PEAK_W-1:0] peak;
    logic [PEAK_W-1:0] mag;

    dith_phase_seq #(
        .HALF_LEN (HALF_LEN)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_en_i (spread_en_i),
        .pos_o    (pos),
        .evt_o    (evt)
    );

    dith_depth_latch #(
        .PEAK_SHALLOW (PEAK_SHALLOW),
        .PEAK_DEEP    (PEAK_DEEP),
        .PEAK_W       (PEAK_W)
    ) u_depth (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (evt.start),
        .shallow_i (depth_sel_i),
        .peak_o    (peak)
    );

    dith_code_map #(
        .POS_W  (POS_W),
        .PEAK_W (PEAK_W),
        .SHIFT  (SHIFT)
    ) u_map (
        .pos_i  (pos),
        .peak_i (peak),
        .mag_o  (mag),
        .ofs_o  (freq_ofs_o)
    );

    assign sweep_fall_o = (evt.phase == PH_FALL);

    // R1
    reset_zero_chk: assert property (@(posedge clk_i)
        rst_i |=> (freq_ofs_o == '0 && !sweep_fall_o));

    // R4
    no_boost_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $signed(freq_ofs_o) <= 0);

    // R6
    slew_limit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (freq_ofs_o == $past(freq_ofs_o)) ||
        (freq_ofs_o == $past(freq_ofs_o) + OUT_W'(1)) ||
        (freq_ofs_o == $past(freq_ofs_o) - OUT_W'(1)));

    // R5
    floor_depth_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pos == POS_W'(HALF_LEN)) |-> (mag == peak));

    // R7
    fall_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sweep_fall_o |=> ($signed(freq_ofs_o) <= $signed($past(freq_ofs_o))));

endmodule

// File: tb/test_tri_dither_gen.sv
module test_tri_dither_gen;

    typedef struct {
        logic signed [7:0] ofs;
        logic              fall;
        string             tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] freq_ofs;
    logic       sweep_fall;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    exp_t q[$];

    // reference model state
    int    m_phase = 0;   // 0 zero, 1 fall, 2 rise
    int    m_pos   = 0;
    int    m_peak  = 64;
    logic  cur_r = 1'b1, cur_e = 1'b0, cur_s = 1'b0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    tri_dither_gen i_tri_dither_gen (
        .clk_i        (clk),
        .rst_i        (rst),
        .spread_en_i  (en),
        .depth_sel_i  (sel),
        .freq_ofs_o   (freq_ofs),
        .sweep_fall_o (sweep_fall)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    // driver: advance model on the edge that consumed the applied inputs
    task automatic step(input logic r, input logic e, input logic s, input string tag);
        exp_t it;
        @(posedge clk);
        #1;
        if (cur_r) begin
            m_phase = 0; m_pos = 0; m_peak = 64;
        end else begin
            case (m_phase)
                0: if (cur_e) begin
                       m_phase = 1; m_pos = 1; m_peak = cur_s ? 32 : 64;
                   end
                1: begin
                       if (m_pos == 2047) m_phase = 2;
                       m_pos = m_pos + 1;
                   end
                default: begin
                       if (m_pos == 1) m_phase = 0;
                       m_pos = m_pos - 1;
                   end
            endcase
        end
        it.ofs  = 8'(-((m_pos * m_peak) / 2048));
        it.fall = (m_phase == 1);
        it.tag  = (m_pos == 2048) ? "R5" : cur_tag;
        q.push_back(it);
        cur_r = r; cur_e = e; cur_s = s; cur_tag = tag;
        rst = r; en = e; sel = s;
    endtask

    // monitor: compare away from the active edge
    initial begin
        logic signed [7:0] prev_ofs;
        logic              prev_fall;
        bit                have_prev;
        int                cyc;
        int                last_rise;
        exp_t              e;
        have_prev = 1'b0;
        prev_fall = 1'b0;
        prev_ofs  = 8'sd0;
        cyc       = 0;
        last_rise = -1;
        forever begin
            @(negedge clk);
            if (q.size() != 0) begin
                e = q.pop_front();
                cyc++;
                // R10 exact code (R5 at the floor, R9 depth, R2/R8 parked zero)
                check($signed(freq_ofs) == e.ofs, e.tag, "R10 offset code",
                      $signed(freq_ofs), e.ofs);
                check(sweep_fall == e.fall, e.tag, "R7 direction flag",
                      int'(sweep_fall), int'(e.fall));
                check($signed(freq_ofs) <= 0, "R4", "offset above nominal",
                      $signed(freq_ofs), 0);
                if (have_prev) begin
                    check(($signed(freq_ofs) - prev_ofs) <= 1 &&
                          ($signed(freq_ofs) - prev_ofs) >= -1,
                          "R6", "step size", $signed(freq_ofs) - prev_ofs, 1);
                end
                if (sweep_fall && !prev_fall) begin
                    if (e.tag == "R3" && last_rise >= 0) begin
                        check(cyc - last_rise == 4096, "R3", "sweep period",
                              cyc - last_rise, 4096);
                    end
                    last_rise = cyc;
                end
                prev_ofs  = $signed(freq_ofs);
                prev_fall = sweep_fall;
                have_prev = 1'b1;
            end
        end
    end

    // stimulus
    initial begin
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, "R1");
        for (int i = 0; i < 100; i++) step(1'b0, 1'b0, 1'b0, "R2");
        for (int i = 0; i < 13000; i++) step(1'b0, 1'b1, 1'b0, "R3");
        // depth flips inside a down-ramp; old depth must persist (R9)
        for (int i = 0; i < 8000; i++) step(1'b0, 1'b1, 1'b1, "R9");
        // enable drops inside a down-ramp; sweep must finish (R8)
        for (int i = 0; i < 5000; i++) step(1'b0, 1'b0, 1'b1, "R8");
        for (int i = 0; i < 50; i++) step(1'b0, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b0, "R2");
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

endmodule